// File: doc/BRIEF.md
# Card Boot and Reset Sequencer

This controller brings a processor card out of power-up. From the power-on reset it holds the card's main processor in reset while two local programmable logic devices load their configurations. Once both devices signal that they are configured, it copies a programmable number of words out of a synchronous boot ROM into working memory, starting at a programmable base address. Only when that copy has finished does it raise the reset-release request to the power manager. The request then stays up until the next power-on reset.

If the two configuration-done inputs are not both high within a fixed number of cycles after reset, the sequencer enters a fault state. It raises an error flag and never releases the processor.

Once the processor runs, it can reload the coprocessor device's configuration. It starts a reload and pushes the image one byte at a time over a valid/ready handshake. The sequencer forwards each byte to a byte-wide configuration port under its control. It reports completion once the coprocessor's done input rises after the final byte.

Top module: `boot_reset_seq`

## Requirements
- R1: While and directly after power-on reset (rstN low), cpuRelease, bootError, cfgBusy, cfgReady, cfgDone and memWrEn are all 0.
- R2: No ROM-to-memory copy starts and cpuRelease stays 0 until devDoneA and devDoneB are both 1 in the same cycle; one of them alone has no effect.
- R3: The copy writes ROM word i (i = 0 .. N-1) to memory address copyBase + i. It makes exactly N writes, where N = copyWords. The ROM returns data one cycle after romAddr. copyBase and copyWords are captured in the cycle the copy starts, and later changes to them are ignored.
- R4: cpuRelease rises only after the last memory write, and memWrEn is never 1 while cpuRelease is 1. A copy count of 0 releases the processor with no memory write.
- R5: Once cpuRelease is 1 it stays 1, whatever devDoneA and devDoneB do, until the next power-on reset.
- R6: If devDoneA and devDoneB are not both 1 within TIMEOUT_CYCLES cycles after reset, bootError becomes 1 and stays 1. cpuRelease is never asserted, and configuration-done inputs that arrive later start no copy.
- R7: A one-cycle cfgStart pulse starts a reload only while cpuRelease is 1 and no reload is in progress. It pulses cfgPortInit for one cycle, sets cfgBusy to 1 and clears cfgDone. A cfgStart before release is ignored.
- R8: During a reload cfgReady is 1 until the last byte is taken. A byte is taken in a cycle with cfgValid and cfgReady both 1, and it appears on cfgPortData with cfgPortStrobe high in the next cycle, in arrival order. While cfgReady is 0, bytes offered on cfgValid are ignored and cause no strobe.
- R9: A byte taken with cfgLast = 1 ends the byte phase. cfgDone becomes 1 and cfgBusy 0 only on a 0-to-1 change of devDoneB that occurs after that last byte; a rise during the byte phase does not count. cfgDone then holds until the next accepted cfgStart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low power-on reset |
| devDoneA | input | 1 | Configuration done from the host-side logic device |
| devDoneB | input | 1 | Configuration done from the coprocessor device |
| copyBase | input | MEM_AW | First working-memory address of the boot copy |
| copyWords | input | ROM_AW+1 | Number of ROM words to copy |
| romAddr | output | ROM_AW | Boot ROM read address |
| romRdEn | output | 1 | Boot ROM read enable |
| romData | input | DATA_W | Boot ROM read data, valid one cycle after the address |
| memWrEn | output | 1 | Working-memory write strobe |
| memAddr | output | MEM_AW | Working-memory write address |
| memWrData | output | DATA_W | Working-memory write data |
| cpuRelease | output | 1 | Request to the power manager to release processor reset |
| bootError | output | 1 | Configuration timeout fault |
| cfgStart | input | 1 | Processor request to begin a configuration reload |
| cfgValid | input | 1 | Reload byte valid |
| cfgByte | input | 8 | Reload byte |
| cfgLast | input | 1 | Marks the final reload byte |
| cfgReady | output | 1 | Sequencer accepts a reload byte |
| cfgBusy | output | 1 | Reload in progress |
| cfgDone | output | 1 | Reload completed |
| cfgPortInit | output | 1 | One-cycle restart pulse to the coprocessor configuration port |
| cfgPortData | output | 8 | Byte on the coprocessor configuration port |
| cfgPortStrobe | output | 1 | Byte strobe on the coprocessor configuration port |

## Verification
The bench holds one configuration-done input high on its own for many cycles. A sequencer that starts on either input would copy too early. Copies of zero words and of the full ROM at the top of memory are checked: an off-by-one read counter would drop or duplicate the last word, and a zero count could hang or make one stray write. The bench also changes the base address during a copy, which catches a design that does not capture it.

The timeout is probed just before and after its limit. Late done inputs are then applied to show that a fault cannot turn into a release. In the reload, the coprocessor done rises in the middle of the byte stream. A design that latches any rise, instead of one seen after the last byte, would report done too early.

// File: rtl/bootseq_pkg.sv
package bootseq_pkg;

  typedef enum logic [1:0] {
    BOOT_WAIT_CFG,
    BOOT_COPY,
    BOOT_RUN,
    BOOT_FAULT
  } bootState_t;

  typedef enum logic [1:0] {
    RLD_IDLE,
    RLD_LOAD,
    RLD_WAIT_DONE
  } reloadState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startCopy;
    logic copyEn;
    logic timerEn;
    logic acceptEn;
    logic startReload;
  } seqCtl_t;

  // status from datapath to control
  typedef struct packed {
    logic copyFinish;
    logic timeout;
    logic byteLast;
    logic doneBRise;
  } seqStat_t;

endpackage

// File: rtl/bootseq_ctrl.sv
module bootseq_ctrl
  import bootseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     devDoneA,
  input  logic     devDoneB,
  input  logic     cfgStart,
  input  seqStat_t stat,
  output seqCtl_t  ctl,
  output logic     cpuRelease,
  output logic     bootError,
  output logic     cfgBusy,
  output logic     cfgDone
);

  bootState_t   bootState, bootNext;
  reloadState_t rldState, rldNext;
  logic         bothDone;
  logic         doneQ;

  assign bothDone = devDoneA && devDoneB;

  always_comb begin
    bootNext = bootState;
    unique case (bootState)
      BOOT_WAIT_CFG: begin
        if (bothDone)          bootNext = BOOT_COPY;
        else if (stat.timeout) bootNext = BOOT_FAULT;
      end
      BOOT_COPY:  if (stat.copyFinish) bootNext = BOOT_RUN;
      BOOT_RUN:   bootNext = BOOT_RUN;
      BOOT_FAULT: bootNext = BOOT_FAULT;
      default:    bootNext = BOOT_FAULT;
    endcase
  end

  always_comb begin
    rldNext = rldState;
    unique case (rldState)
      RLD_IDLE:      if (bootState == BOOT_RUN && cfgStart) rldNext = RLD_LOAD;
      RLD_LOAD:      if (stat.byteLast) rldNext = RLD_WAIT_DONE;
      RLD_WAIT_DONE: if (stat.doneBRise) rldNext = RLD_IDLE;
      default:       rldNext = RLD_IDLE;
    endcase
  end

  always_comb begin
    ctl.startCopy   = (bootState == BOOT_WAIT_CFG) && bothDone;
    ctl.copyEn      = (bootState == BOOT_COPY);
    ctl.timerEn     = (bootState == BOOT_WAIT_CFG);
    ctl.acceptEn    = (rldState == RLD_LOAD);
    ctl.startReload = (rldState == RLD_IDLE) && (bootState == BOOT_RUN) && cfgStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bootState <= BOOT_WAIT_CFG;
      rldState  <= RLD_IDLE;
      doneQ     <= 1'b0;
    end else begin
      bootState <= bootNext;
      rldState  <= rldNext;
      if (ctl.startReload)
        doneQ <= 1'b0;
      else if (rldState == RLD_WAIT_DONE && stat.doneBRise)
        doneQ <= 1'b1;
    end
  end

  assign cpuRelease = (bootState == BOOT_RUN);
  assign bootError  = (bootState == BOOT_FAULT);
  assign cfgBusy    = (rldState != RLD_IDLE);
  assign cfgDone    = doneQ;

endmodule

// File: rtl/bootseq_datapath.sv
module bootseq_datapath
  import bootseq_pkg::*;
#(
  parameter int ROM_AW         = 8,
  parameter int MEM_AW         = 12,
  parameter int DATA_W         = 16,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  output seqStat_t          stat,
  input  logic              devDoneB,
  input  logic [MEM_AW-1:0] copyBase,
  input  logic [ROM_AW:0]   copyWords,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romRdEn,
  input  logic [DATA_W-1:0] romData,
  output logic              memWrEn,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic              cfgValid,
  input  logic [7:0]        cfgByte,
  input  logic              cfgLast,
  output logic              cfgReady,
  output logic              cfgPortInit,
  output logic [7:0]        cfgPortData,
  output logic              cfgPortStrobe
);

  localparam int CNT_W = ROM_AW + 1;
  localparam int TMR_W = $clog2(TIMEOUT_CYCLES + 1);

  logic [CNT_W-1:0]  rdIdx, wordCnt;
  logic [MEM_AW-1:0] baseQ;
  logic [ROM_AW-1:0] wrOff;
  logic              issue, issueQ;
  logic [TMR_W-1:0]  tmr;
  logic              prevDoneB;
  logic              accept;

  assign issue  = ctl.copyEn && (rdIdx < wordCnt);
  assign accept = cfgValid && ctl.acceptEn;

  // copy engine: read stage then write stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdIdx   <= '0;
      wordCnt <= '0;
      baseQ   <= '0;
      wrOff   <= '0;
      issueQ  <= 1'b0;
    end else if (ctl.startCopy) begin
      rdIdx   <= '0;
      wordCnt <= copyWords;
      baseQ   <= copyBase;
      issueQ  <= 1'b0;
    end else begin
      issueQ <= issue;
      if (issue) begin
        rdIdx <= rdIdx + CNT_W'(1);
        wrOff <= rdIdx[ROM_AW-1:0];
      end
    end
  end

  // configuration timeout timer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            tmr <= '0;
    else if (ctl.timerEn) tmr <= tmr + TMR_W'(1);
  end

  // reload byte forwarding
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgPortData   <= '0;
      cfgPortStrobe <= 1'b0;
      cfgPortInit   <= 1'b0;
      prevDoneB     <= 1'b0;
    end else begin
      cfgPortStrobe <= accept;
      if (accept) cfgPortData <= cfgByte;
      cfgPortInit <= ctl.startReload;
      prevDoneB   <= devDoneB;
    end
  end

  assign romAddr   = rdIdx[ROM_AW-1:0];
  assign romRdEn   = issue;
  assign memWrEn   = issueQ;
  assign memAddr   = baseQ + MEM_AW'(wrOff);
  assign memWrData = romData;
  assign cfgReady  = ctl.acceptEn;

  always_comb begin
    stat.copyFinish = ctl.copyEn && !issue && !issueQ;
    stat.timeout    = ctl.timerEn && (tmr == TMR_W'(TIMEOUT_CYCLES - 1));
    stat.byteLast   = accept && cfgLast;
    stat.doneBRise  = devDoneB && !prevDoneB;
  end

endmodule

// File: rtl/boot_reset_seq.sv
module boot_reset_seq
  import bootseq_pkg::*;
#(
  parameter int ROM_AW         = 8,
  parameter int MEM_AW         = 12,
  parameter int DATA_W         = 16,
  parameter int TIMEOUT_CYCLES = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              devDoneA,
  input  logic              devDoneB,
  input  logic [MEM_AW-1:0] copyBase,
  input  logic [ROM_AW:0]   copyWords,
  output logic [ROM_AW-1:0] romAddr,
  output logic              romRdEn,
  input  logic [DATA_W-1:0] romData,
  output logic              memWrEn,
  output logic [MEM_AW-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  output logic              cpuRelease,
  output logic              bootError,
  input  logic              cfgStart,
  input  logic              cfgValid,
  input  logic [7:0]        cfgByte,
  input  logic              cfgLast,
  output logic              cfgReady,
  output logic              cfgBusy,
  output logic              cfgDone,
  output logic              cfgPortInit,
  output logic [7:0]        cfgPortData,
  output logic              cfgPortStrobe
);

  seqCtl_t  ctl;
  seqStat_t stat;

  bootseq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .devDoneA   (devDoneA),
    .devDoneB   (devDoneB),
    .cfgStart   (cfgStart),
    .stat       (stat),
    .ctl        (ctl),
    .cpuRelease (cpuRelease),
    .bootError  (bootError),
    .cfgBusy    (cfgBusy),
    .cfgDone    (cfgDone)
  );

  bootseq_datapath #(
    .ROM_AW         (ROM_AW),
    .MEM_AW         (MEM_AW),
    .DATA_W         (DATA_W),
    .TIMEOUT_CYCLES (TIMEOUT_CYCLES)
  ) u_dp (
    .clk           (clk),
    .rstN          (rstN),
    .ctl           (ctl),
    .stat          (stat),
    .devDoneB      (devDoneB),
    .copyBase      (copyBase),
    .copyWords     (copyWords),
    .romAddr       (romAddr),
    .romRdEn       (romRdEn),
    .romData       (romData),
    .memWrEn       (memWrEn),
    .memAddr       (memAddr),
    .memWrData     (memWrData),
    .cfgValid      (cfgValid),
    .cfgByte       (cfgByte),
    .cfgLast       (cfgLast),
    .cfgReady      (cfgReady),
    .cfgPortInit   (cfgPortInit),
    .cfgPortData   (cfgPortData),
    .cfgPortStrobe (cfgPortStrobe)
  );

endmodule

// File: rtl/bootseq_checker.sv
module bootseq_checker (
  input logic clk,
  input logic rstN,
  input logic cpuRelease,
  input logic bootError,
  input logic memWrEn,
  input logic cfgValid,
  input logic cfgReady,
  input logic cfgBusy,
  input logic cfgDone,
  input logic cfgPortInit,
  input logic cfgPortStrobe
);

  // R4: memory writes never overlap the release
  a_r4_no_write_after_release: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !cpuRelease);

  // R5: release is sticky
  a_r5_release_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(cpuRelease) |-> cpuRelease);

  // R6: fault excludes release and copy, and is sticky
  a_r6_fault_blocks_release: assert property (@(posedge clk) disable iff (!rstN)
    bootError |-> (!cpuRelease && !memWrEn));
  a_r6_fault_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(bootError) |-> bootError);

  // R7: reload only after release, and it opens with an init pulse
  a_r7_init_after_release: assert property (@(posedge clk) disable iff (!rstN)
    cfgPortInit |-> cpuRelease);
  a_r7_busy_starts_with_init: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cfgBusy) |-> cfgPortInit);

  // R8: strobe only follows a handshake, ready only during a reload
  a_r8_strobe_follows_accept: assert property (@(posedge clk) disable iff (!rstN)
    cfgPortStrobe |-> $past(cfgValid && cfgReady));
  a_r8_ready_within_busy: assert property (@(posedge clk) disable iff (!rstN)
    cfgReady |-> cfgBusy);

  // R9: done and busy are exclusive
  a_r9_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    !(cfgDone && cfgBusy));

endmodule

bind boot_reset_seq bootseq_checker u_chk (
  .clk           (clk),
  .rstN          (rstN),
  .cpuRelease    (cpuRelease),
  .bootError     (bootError),
  .memWrEn       (memWrEn),
  .cfgValid      (cfgValid),
  .cfgReady      (cfgReady),
  .cfgBusy       (cfgBusy),
  .cfgDone       (cfgDone),
  .cfgPortInit   (cfgPortInit),
  .cfgPortStrobe (cfgPortStrobe)
);

// File: tb/tb_boot_reset_seq.sv
`timescale 1ns/1ps
module tb_boot_reset_seq;

  localparam int ROM_AW = 8;
  localparam int MEM_AW = 12;
  localparam int DATA_W = 16;
  localparam int TMO    = 1000;

  logic clk = 1'b0;
  logic rstN;
  logic devDoneA, devDoneB;
  logic [MEM_AW-1:0] copyBase;
  logic [ROM_AW:0]   copyWords;
  logic [ROM_AW-1:0] romAddr;
  logic              romRdEn;
  logic [DATA_W-1:0] romData;
  logic              memWrEn;
  logic [MEM_AW-1:0] memAddr;
  logic [DATA_W-1:0] memWrData;
  logic cpuRelease, bootError;
  logic cfgStart, cfgValid, cfgLast, cfgReady, cfgBusy, cfgDone;
  logic [7:0] cfgByte;
  logic cfgPortInit, cfgPortStrobe;
  logic [7:0] cfgPortData;

  always #2 clk = ~clk;

  boot_reset_seq #(.ROM_AW(ROM_AW), .MEM_AW(MEM_AW), .DATA_W(DATA_W), .TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rstN(rstN), .devDoneA(devDoneA), .devDoneB(devDoneB),
    .copyBase(copyBase), .copyWords(copyWords), .romAddr(romAddr), .romRdEn(romRdEn),
    .romData(romData), .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData),
    .cpuRelease(cpuRelease), .bootError(bootError), .cfgStart(cfgStart),
    .cfgValid(cfgValid), .cfgByte(cfgByte), .cfgLast(cfgLast), .cfgReady(cfgReady),
    .cfgBusy(cfgBusy), .cfgDone(cfgDone), .cfgPortInit(cfgPortInit),
    .cfgPortData(cfgPortData), .cfgPortStrobe(cfgPortStrobe)
  );

  // models: synchronous ROM and working memory
  logic [DATA_W-1:0] romArr [1 << ROM_AW];
  logic [DATA_W-1:0] memArr [1 << MEM_AW];
  int writes, lateWrites, strobes, inits;
  logic [7:0] byteLog [64];
  int checks = 0, failures = 0;

  always @(posedge clk) begin
    romData <= romArr[romAddr];
    if (memWrEn) begin
      memArr[memAddr] = memWrData;
      writes++;
      if (cpuRelease) lateWrites++;
    end
    if (cfgPortStrobe) begin
      if (strobes < 64) byteLog[strobes] = cfgPortData;
      strobes++;
    end
    if (cfgPortInit) inits++;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; devDoneA = 0; devDoneB = 0; copyBase = '0; copyWords = '0;
    cfgStart = 0; cfgValid = 0; cfgByte = '0; cfgLast = 0;
    for (int i = 0; i < (1 << MEM_AW); i++) memArr[i] = 16'hDEAD;
    writes = 0; lateWrites = 0; strobes = 0; inits = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic waitRelease(input int limit);
    for (int i = 0; i < limit && !cpuRelease; i++) @(negedge clk);
  endtask

  function automatic int mismatches(input int base, input int n);
    int bad = 0;
    for (int i = 0; i < n; i++)
      if (memArr[base + i] !== romArr[i]) bad++;
    return bad;
  endfunction

  task automatic bootCard(input int base, input int n);
    copyBase = MEM_AW'(base); copyWords = (ROM_AW+1)'(n);
    devDoneA = 1; devDoneB = 1;
    waitRelease(600);
  endtask

  task automatic testReset();
    doReset();
    check(!cpuRelease && !bootError, "R1 release/error", {cpuRelease, bootError}, 0);
    check(!cfgBusy && !cfgReady && !cfgDone, "R1 reload flags", {cfgBusy, cfgReady, cfgDone}, 0);
    check(!memWrEn && writes == 0, "R1 no writes", writes, 0);
  endtask

  task automatic testGateAndCopy();
    doReset();
    copyBase = 12'h100; copyWords = 9'd40;
    devDoneA = 1;
    repeat (60) @(negedge clk);
    check(writes == 0 && !cpuRelease, "R2 one done alone", writes, 0);
    cfgStart = 1; @(negedge clk); cfgStart = 0; @(negedge clk);
    check(!cfgBusy && inits == 0, "R7 start before release ignored", inits, 0);
    devDoneB = 1;
    repeat (3) @(negedge clk);
    copyBase = 12'h800; copyWords = 9'd5;
    waitRelease(400);
    check(cpuRelease, "R4 release after copy", cpuRelease, 1);
    check(writes == 40, "R3 write count", writes, 40);
    check(mismatches(12'h100, 40) == 0, "R3 data at base+i", mismatches(12'h100, 40), 0);
    check(memArr[12'h100 + 40] === 16'hDEAD, "R3 nothing past end", memArr[12'h100 + 40], 16'hDEAD);
    check(memArr[12'h800] === 16'hDEAD, "R3 late base change ignored", memArr[12'h800], 16'hDEAD);
    check(lateWrites == 0, "R4 no write with release", lateWrites, 0);
    devDoneA = 0; devDoneB = 0;
    repeat (20) @(negedge clk);
    check(cpuRelease, "R5 release sticky", cpuRelease, 1);
  endtask

  task automatic testCountEdges();
    doReset();
    bootCard(12'h040, 0);
    repeat (5) @(negedge clk);
    check(cpuRelease && writes == 0, "R4 zero count", writes, 0);
    doReset();
    bootCard(12'hF00, 256);
    check(cpuRelease && writes == 256, "R3 full ROM count", writes, 256);
    check(mismatches(12'hF00, 256) == 0, "R3 full ROM data", mismatches(12'hF00, 256), 0);
    check(lateWrites == 0, "R4 full ROM ordering", lateWrites, 0);
  endtask

  task automatic testTimeout();
    doReset();
    copyWords = 9'd8;
    devDoneB = 1;
    repeat (TMO - 100) @(negedge clk);
    check(!bootError, "R6 no fault before limit", bootError, 0);
    repeat (200) @(negedge clk);
    check(bootError && !cpuRelease, "R6 fault after limit", {bootError, cpuRelease}, 2);
    devDoneA = 1;
    repeat (300) @(negedge clk);
    check(writes == 0 && !cpuRelease && bootError, "R6 late dones ignored", writes, 0);
  endtask

  task automatic sendByte(input logic [7:0] b, input logic last, input int gap);
    cfgValid = 1; cfgByte = b; cfgLast = last;
    @(negedge clk);
    cfgValid = 0; cfgLast = 0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic testReload();
    logic [7:0] img [6];
    int bad;
    img = '{8'hA5, 8'h3C, 8'h00, 8'hFF, 8'h81, 8'h7E};
    doReset();
    bootCard(12'h000, 4);
    devDoneB = 0;
    cfgValid = 1; cfgByte = 8'h55;
    repeat (5) @(negedge clk);
    cfgValid = 0;
    check(strobes == 0, "R8 byte before reload ignored", strobes, 0);
    cfgStart = 1; @(negedge clk); cfgStart = 0;
    check(cfgBusy && cfgReady && !cfgDone, "R7 reload begins", {cfgBusy, cfgReady, cfgDone}, 6);
    @(negedge clk);
    check(inits == 1, "R7 single init pulse", inits, 1);
    for (int i = 0; i < 6; i++) begin
      if (i == 3) devDoneB = 1;
      sendByte(img[i], i == 5, i % 3);
    end
    check(!cfgReady && cfgBusy, "R9 byte phase closed", {cfgReady, cfgBusy}, 1);
    repeat (10) @(negedge clk);
    check(!cfgDone && cfgBusy, "R9 early rise ignored", cfgDone, 0);
    sendByte(8'h99, 1'b0, 2);
    check(strobes == 6, "R8 byte after last ignored", strobes, 6);
    bad = 0;
    for (int i = 0; i < 6; i++) if (byteLog[i] !== img[i]) bad++;
    check(bad == 0, "R8 bytes in order", bad, 0);
    devDoneB = 0; repeat (3) @(negedge clk);
    devDoneB = 1; repeat (3) @(negedge clk);
    check(cfgDone && !cfgBusy, "R9 done on rise after last", {cfgDone, cfgBusy}, 2);
    repeat (5) @(negedge clk);
    check(cfgDone, "R9 done held", cfgDone, 1);
    cfgStart = 1; @(negedge clk); cfgStart = 0;
    check(!cfgDone && cfgBusy, "R9 done cleared by new start", cfgDone, 0);
  endtask

  initial begin
    for (int i = 0; i < (1 << ROM_AW); i++) romArr[i] = DATA_W'((i * 40503) ^ 23130);
    testReset();
    testGateAndCopy();
    testCountEdges();
    testTimeout();
    testReload();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule